// File: doc/BRIEF.md
# Status Flag Update and Condition Evaluator

This block holds the four processor status flags (negative, zero, carry, overflow) and keeps them current as results leave an execution datapath. Each cycle the datapath presents a 32-bit result, the carry (or borrow) and overflow produced alongside it, a 3-bit operation class and a set-flags bit. When the valid strobe is high and the class and set-flags bit call for it, the block computes new flags and latches them on the clock edge. Logical classes take the carry from the shifter and keep the stored overflow.

In parallel, a 4-bit condition field is tested against the flags already held in the register. The result is a pass signal that the issue stage uses as an execute-enable. Flags being computed in the same cycle never affect that test. The flag register is cleared by a synchronous reset.

Top module: `flag_cond_unit`

## Requirements
- R1: On a flag write, N (flags_o[3]) takes bit 31 of result_i.
- R2: On a flag write, Z (flags_o[2]) is 1 exactly when result_i is all zeros.
- R3: On a flag write, C (flags_o[1]) is set as follows. For the add classes ADD (000) and CMN (100), C equals carry_i as a carry-out. For the subtract classes SUB (001) and CMP (011), carry_i is a borrow and C is its inverse, so C=1 means no borrow. For the logical classes LOGIC (010), TST (101) and TEQ (110), C equals carry_i as the shifter carry.
- R4: On a flag write, V (flags_o[0]) equals ovf_i for the add and subtract classes. For the logical classes V keeps its stored value.
- R5: A write happens when valid_i=1 and either set_flags_i=1 with class ADD, SUB or LOGIC, or the class is CMP, CMN, TST or TEQ, whatever set_flags_i is. Class 111 never writes. In every other case the flags hold.
- R6: While valid_i=0, the flags do not change, whatever the other inputs are.
- R7: Simple conditions, evaluated from the stored flags: 0000 passes on Z=1, 0001 on Z=0, 0010 on C=1, 0011 on C=0, 0100 on N=1, 0101 on N=0, 0110 on V=1, 0111 on V=0.
- R8: Compound conditions:
  - 1000 passes on C=1 and Z=0.
  - 1001 passes on C=0 or Z=1.
  - 1010 passes on N==V.
  - 1011 passes on N!=V.
  - 1100 passes on Z=0 and N==V.
  - 1101 passes on Z=1 or N!=V.
- R9: Conditions 1110 and 1111 always pass.
- R10: pass_o is combinational from cond_i and the flags held in the register. A write made in the same cycle affects pass_o only after the clock edge.
- R11: A synchronous reset (rst high at a clock edge) clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Result strobe |
| result_i | input | 32 | Datapath result |
| carry_i | input | 1 | Carry-out (add), borrow (subtract) or shifter carry (logical) |
| ovf_i | input | 1 | Signed overflow from the adder |
| op_i | input | 3 | Operation class |
| set_flags_i | input | 1 | Request to write flags |
| cond_i | input | 4 | Condition field |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |
| pass_o | output | 1 | Condition pass / execute-enable |

## Verification
The assertions rely on three assumptions about the inputs: they are stable around each rising edge, op_i carries a defined value, and rst is a clean level. They make no assumption about the relation between result_i, carry_i and ovf_i. The bench therefore drives arbitrary, even inconsistent, combinations of these three, always at the falling edge, which keeps it inside what the assertions assume. Every condition code is swept against each reachable flag pattern while valid_i is held low. Those sweeps never disturb the stored state.

// File: rtl/flag_cond_pkg.sv
package flag_cond_pkg;
  localparam int COND_W = 4;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_LOGIC = 3'd2,
    OP_CMP   = 3'd3,
    OP_CMN   = 3'd4,
    OP_TST   = 3'd5,
    OP_TEQ   = 3'd6,
    OP_NONE  = 3'd7
  } op_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic is_sub_class(input logic [OP_W-1:0] op);
    return (op == OP_SUB) || (op == OP_CMP);
  endfunction

  function automatic logic is_logic_class(input logic [OP_W-1:0] op);
    return (op == OP_LOGIC) || (op == OP_TST) || (op == OP_TEQ);
  endfunction

  function automatic logic forces_write(input logic [OP_W-1:0] op);
    return (op == OP_CMP) || (op == OP_CMN) || (op == OP_TST) || (op == OP_TEQ);
  endfunction

  function automatic logic cond_holds(input logic [COND_W-1:0] cc, input flags_t f);
    logic r;
    case (cc)
      4'd0:    r = f.z;
      4'd1:    r = !f.z;
      4'd2:    r = f.c;
      4'd3:    r = !f.c;
      4'd4:    r = f.n;
      4'd5:    r = !f.n;
      4'd6:    r = f.v;
      4'd7:    r = !f.v;
      4'd8:    r = f.c && !f.z;
      4'd9:    r = !f.c || f.z;
      4'd10:   r = (f.n == f.v);
      4'd11:   r = (f.n != f.v);
      4'd12:   r = !f.z && (f.n == f.v);
      4'd13:   r = f.z || (f.n != f.v);
      default: r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import flag_cond_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  input  logic              carry,
  input  logic              ovf,
  input  logic [OP_W-1:0]   op,
  input  flags_t            cur,
  output flags_t            nxt
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    nxt.n = result[MSB];
    nxt.z = ~|result;
    if (is_sub_class(op)) nxt.c = ~carry;
    else                  nxt.c = carry;
    if (is_logic_class(op)) nxt.v = cur.v;
    else                    nxt.v = ovf;
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flag_cond_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic            set_flags,
  input  logic [OP_W-1:0] op,
  input  flags_t          nxt,
  output logic            wr_en,
  output flags_t          q
);
  assign wr_en = valid && (op != OP_NONE) && (set_flags || forces_write(op));

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= nxt;
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import flag_cond_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  flags_t            flags,
  output logic              pass
);
  assign pass = cond_holds(cond, flags);
endmodule

// File: rtl/flag_cond_unit.sv
module flag_cond_unit
  import flag_cond_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic [2:0]        op_i,
  input  logic              set_flags_i,
  input  logic [3:0]        cond_i,
  output logic [3:0]        flags_o,
  output logic              pass_o
);
  flags_t cur_flags;
  flags_t nxt_flags;
  logic   wr_en;
  logic   logic_op;

  assign logic_op = is_logic_class(op_i);

  flag_calc #(.DATA_W(DATA_W)) u_calc (
    .result(result_i), .carry(carry_i), .ovf(ovf_i), .op(op_i),
    .cur(cur_flags), .nxt(nxt_flags)
  );

  flag_reg u_reg (
    .clk(clk), .rst(rst), .valid(valid_i), .set_flags(set_flags_i),
    .op(op_i), .nxt(nxt_flags), .wr_en(wr_en), .q(cur_flags)
  );

  cond_eval u_cond (.cond(cond_i), .flags(cur_flags), .pass(pass_o));

  assign flags_o = cur_flags;
endmodule

// File: rtl/flag_cond_chk.sv
module flag_cond_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [DATA_W-1:0] result_i,
  input logic [3:0]        cond_i,
  input logic [3:0]        flags_o,
  input logic              pass_o,
  input logic              wr_en,
  input logic              logic_op
);
  a_r11_reset_clear: assert property (@(posedge clk) rst |=> (flags_o == 4'b0));
  a_r1_neg: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (flags_o[3] == $past(result_i[DATA_W-1])));
  a_r2_zero: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (flags_o[2] == ($past(result_i) == '0)));
  a_r4_logic_keeps_v: assert property (@(posedge clk) disable iff (rst)
    (wr_en && logic_op) |=> $stable(flags_o[0]));
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(flags_o));
  a_r9_always: assert property (@(posedge clk) disable iff (rst)
    (cond_i[3:1] == 3'b111) |-> pass_o);
  a_r7_eq: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'd0) |-> (pass_o == flags_o[2]));
  a_r8_ge: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'd10) |-> (pass_o == (flags_o[3] == flags_o[0])));
endmodule

bind flag_cond_unit flag_cond_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .result_i(result_i),
  .cond_i(cond_i), .flags_o(flags_o), .pass_o(pass_o),
  .wr_en(wr_en), .logic_op(logic_op)
);

// File: tb/flag_cond_unit_tb_top.sv
module flag_cond_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] result_i = '0;
  logic        carry_i = 1'b0;
  logic        ovf_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic        set_flags_i = 1'b0;
  logic [3:0]  cond_i = 4'd0;
  logic [3:0]  flags_o;
  logic        pass_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [3:0] fl;
    logic       ps;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [3:0] model = 4'b0;

  always #4 clk = ~clk;

  flag_cond_unit dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .result_i(result_i),
    .carry_i(carry_i), .ovf_i(ovf_i), .op_i(op_i), .set_flags_i(set_flags_i),
    .cond_i(cond_i), .flags_o(flags_o), .pass_o(pass_o)
  );

  function automatic logic exp_pass(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    if (cc >= 4'd14) return 1'b1;
    case (cc[3:1])
      3'd0: return z ^ cc[0];
      3'd1: return c ^ cc[0];
      3'd2: return n ^ cc[0];
      3'd3: return v ^ cc[0];
      3'd4: return (c & ~z) ^ cc[0];
      3'd5: return (n ~^ v) ^ cc[0];
      default: return (~z & (n ~^ v)) ^ cc[0];
    endcase
  endfunction

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual flags/pass=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [31:0] res, input logic cy,
                      input logic ov, input logic sf, input logic [3:0] cc,
                      input logic v, input string tag);
    logic wr;
    logic [3:0] nf;
    exp_t it;
    @(negedge clk);
    op_i = op; result_i = res; carry_i = cy; ovf_i = ov;
    set_flags_i = sf; cond_i = cc; valid_i = v;
    #1;
    check({flags_o, pass_o}, {model, exp_pass(cc, model)}, "R10");
    wr = v && (op != 3'd7) && (sf || (op >= 3'd3));
    nf = model;
    if (wr) begin
      nf[3] = res[31];
      nf[2] = (res == 32'd0);
      case (op)
        3'd1, 3'd3: begin nf[1] = !cy; nf[0] = ov; end
        3'd0, 3'd4: begin nf[1] = cy;  nf[0] = ov; end
        default:    begin nf[1] = cy; end
      endcase
    end
    model = nf;
    it.fl = nf; it.ps = exp_pass(cc, nf); it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        it = q.pop_front();
        check({flags_o, pass_o}, {it.fl, it.ps}, it.tag);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check({flags_o, pass_o}, {4'b0000, 1'b0}, "R11");
    // R1 R2 R3: add with zero result and carry
    step(3'd0, 32'd0, 1'b1, 1'b0, 1'b1, 4'd0, 1'b1, "R2");
    step(3'd0, 32'h8000_0001, 1'b0, 1'b1, 1'b1, 4'd4, 1'b1, "R1");
    // R5: add without set-flags holds
    step(3'd0, 32'd0, 1'b1, 1'b0, 1'b0, 4'd6, 1'b1, "R5");
    // R3: compare, no borrow -> C=1, even with set-flags low
    step(3'd3, 32'd5, 1'b0, 1'b0, 1'b0, 4'd2, 1'b1, "R3");
    // R3: subtract with borrow -> C=0
    step(3'd1, 32'h7fff_ffff, 1'b1, 1'b1, 1'b1, 4'd3, 1'b1, "R3");
    // R4: logical keeps V=1, takes shifter carry
    step(3'd2, 32'h8000_0000, 1'b1, 1'b0, 1'b1, 4'd6, 1'b1, "R4");
    step(3'd5, 32'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, "R4");
    step(3'd6, 32'd3, 1'b1, 1'b0, 1'b0, 4'd7, 1'b1, "R5");
    // R5: class 111 never writes
    step(3'd7, 32'd0, 1'b1, 1'b1, 1'b1, 4'd0, 1'b1, "R5");
    // R6: valid low ignored
    step(3'd4, 32'd0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, "R6");
    // R4: CMN writes V from ovf
    step(3'd4, 32'd9, 1'b1, 1'b1, 1'b0, 4'd6, 1'b1, "R4");
    // condition sweep over flag patterns
    for (int i = 0; i < 16; i++) begin
      logic [31:0] r;
      r = i[3] ? 32'h8000_0000 : (i[2] ? 32'd0 : 32'd1);
      step(3'd4, r, i[1], i[0], 1'b0, 4'd14, 1'b1, "R9");
      for (int c = 0; c < 16; c++)
        step(3'd0, 32'd0, 1'b1, 1'b1, 1'b1, c[3:0], 1'b0,
             (c < 8) ? "R7" : ((c < 14) ? "R8" : "R9"));
    end
    // R11: reset mid-run clears flags
    step(3'd4, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 4'd0, 1'b1, "R1");
    @(negedge clk);
    valid_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cond_i = 4'd1;
    #1;
    check({flags_o, pass_o}, {4'b0000, 1'b1}, "R11");
    model = 4'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule